// File: doc/BRIEF.md
# Pixel Window Transfer Engine

The engine accepts a stream of 16-bit words written into a rectangular window of a frame buffer. Configuration inputs give the window's corner coordinates, a pixel format code and a source select. From these the engine checks that the window is usable and works out its width, its height and the number of 16-bit words that fill it. Each accepted word is sent out with the frame-buffer byte address it belongs to. When the last word of the window has been written, the engine gives a one-cycle completion pulse.

A transfer is set up in one of two ways. A write to the source-select register sets it up directly. A data word that arrives while no transfer is open sets it up on the spot, and that word becomes the first word of the window. A data word that arrives while no valid setup is possible is dropped, and a sticky error flag is raised.

The engine also keeps a dirty rectangle, which is the union of all windows completed since the refresh logic last took it. The refresh logic takes the rectangle with a consume pulse, and the rectangle then goes back to empty.

Top module: `pix_window_xfer`

## Requirements
- R1: The bytes per pixel follow the format code in `fmt_i`. Code 1 gives 2 bytes, codes 2 and 3 give 3 bytes, codes 6 and 7 give 4 bytes. Every other code gives 0 and counts as unsupported.
- R2: A setup is invalid in any of these cases: `src_sel_i` is above 3, the format is unsupported, `win_xe_i < win_xs_i`, or `win_ye_i < win_ys_i`. A data write that meets an invalid setup while no transfer is open is dropped: `fb_we_o` stays low, `busy_o` stays low, the dirty rectangle is unchanged, and `err_o` is set.
- R3: A window holds floor(bpp * W * H / 2) words, where W = xe - xs + 1 and H = ye - ys + 1. The window completes on the write of its last word.
- R4: A pulse on `src_wr_i` with a valid setup starts a new transfer with a fresh count and drops any transfer in progress. A pulse with an invalid setup leaves the open transfer untouched. A data write in the same cycle as `src_wr_i` is dropped without setting `err_o`.
- R5: A data write that arrives while `busy_o` is low sets up from the current inputs and is stored as word 0 of the window. `busy_o` is high in the cycles that follow, for as long as words remain.
- R6: An accepted word drives `fb_we_o` high, with `fb_data_o` equal to `data_i`, in the cycle of the write. Word k goes to byte address ((ys + r) * panel_w + xs) * bpp + c, where r = (2k) div (bpp * W) and c = (2k) mod (bpp * W).
- R7: `done_o` is high for exactly one cycle, in the cycle after the last word's write. In that cycle `busy_o` is low.
- R8: On completion the dirty rectangle becomes the union of its old value and the window. Its minimum corner takes the smaller start coordinates, and its maximum corner takes the larger of start plus size. The new value is visible together with `done_o`. Otherwise the rectangle holds its value.
- R9: A `consume_i` pulse resets the dirty rectangle in the next cycle to x0 = `panel_w_i`, x1 = 0, y0 = `panel_h_i`, y1 = 0. If a window completes in the same cycle, the result is that window alone.
- R10: `err_o` stays set until reset.
- R11: After reset `busy_o`, `done_o`, `err_o` and `fb_we_o` are low, the dirty minimum corner is 2^CW on both axes, and the maximum corner is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_xs_i | input | CW | Window start X |
| win_ys_i | input | CW | Window start Y |
| win_xe_i | input | CW | Window end X (inclusive) |
| win_ye_i | input | CW | Window end Y (inclusive) |
| fmt_i | input | 4 | Pixel format code |
| src_sel_i | input | 3 | Source select value |
| src_wr_i | input | 1 | Source-select register write, triggers setup |
| data_wr_i | input | 1 | Data-port write strobe |
| data_i | input | 16 | Data-port word |
| panel_w_i | input | CW | Panel width in pixels |
| panel_h_i | input | CW | Panel height in lines |
| consume_i | input | 1 | Refresh logic takes the dirty rectangle |
| fb_we_o | output | 1 | Frame-buffer write enable |
| fb_addr_o | output | 2*CW+2 | Frame-buffer byte address of the word |
| fb_data_o | output | 16 | Frame-buffer write data |
| busy_o | output | 1 | Words remain in the open window |
| done_o | output | 1 | Window completed, one-cycle pulse |
| err_o | output | 1 | Sticky: a data word was dropped for an invalid setup |
| dirty_x0_o | output | CW+1 | Dirty rectangle minimum X |
| dirty_y0_o | output | CW+1 | Dirty rectangle minimum Y |
| dirty_x1_o | output | CW+1 | Dirty rectangle maximum X (exclusive) |
| dirty_y1_o | output | CW+1 | Dirty rectangle maximum Y (exclusive) |

## Verification
The bench builds the engine with CW = 6, so coordinates run from 0 to 63. At this size a window can end on coordinate 63, which drives the dirty maximum up to 64, the first value that needs the extra bit. The reset-empty value of 64 is the same boundary seen from the other side. The small width also keeps each window down to a few dozen words. That makes room for many random windows across all supported formats, including odd byte counts such as the 3-byte format on a single pixel, where the word count rounds down to 1.

// File: rtl/pwx_pkg.sv
`timescale 1ns/1ps
package pwx_pkg;
  // bytes per pixel for a format code, 0 = unsupported
  function automatic logic [2:0] fmt_bytes(input logic [3:0] code);
    case (code)
      4'd1:       fmt_bytes = 3'd2;
      4'd2, 4'd3: fmt_bytes = 3'd3;
      4'd6, 4'd7: fmt_bytes = 3'd4;
      default:    fmt_bytes = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/pwx_setup.sv
`timescale 1ns/1ps
module pwx_setup #(
  parameter int CW = 10
) (
  input  logic [CW-1:0]     xs_i,
  input  logic [CW-1:0]     ys_i,
  input  logic [CW-1:0]     xe_i,
  input  logic [CW-1:0]     ye_i,
  input  logic [3:0]        fmt_i,
  input  logic [2:0]        src_i,
  input  logic [CW-1:0]     panel_w_i,
  output logic              ok_o,
  output logic [CW:0]       dx_o,
  output logic [CW:0]       dy_o,
  output logic [2*CW+1:0]   len_o,
  output logic [CW+2:0]     row_bytes_o,
  output logic [2*CW+1:0]   line_bytes_o,
  output logic [2*CW+1:0]   row_base_o,
  output logic [2*CW+1:0]   x_off_o
);
  localparam int DW = CW + 1;
  localparam int AW = 2 * CW + 2;
  localparam int RW = CW + 3;
  localparam int PW = 2 * CW + 4;

  logic [2:0]    bpp;
  logic [PW-1:0] prod;

  always_comb begin
    bpp          = pwx_pkg::fmt_bytes(fmt_i);
    ok_o         = (src_i <= 3'd3) && (bpp != 3'd0) && (xe_i >= xs_i) && (ye_i >= ys_i);
    dx_o         = DW'(xe_i) - DW'(xs_i) + DW'(1);
    dy_o         = DW'(ye_i) - DW'(ys_i) + DW'(1);
    row_bytes_o  = RW'(bpp) * RW'(dx_o);
    prod         = PW'(row_bytes_o) * PW'(dy_o);
    len_o        = AW'(prod >> 1);
    line_bytes_o = AW'(panel_w_i) * AW'(bpp);
    row_base_o   = AW'(ys_i) * line_bytes_o;
    x_off_o      = AW'(xs_i) * AW'(bpp);
  end
endmodule

// File: rtl/pwx_addr.sv
`timescale 1ns/1ps
module pwx_addr #(
  parameter int CW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              fresh_i,
  input  logic [CW+2:0]     s_row_bytes_i,
  input  logic [2*CW+1:0]   s_line_bytes_i,
  input  logic [2*CW+1:0]   s_row_base_i,
  input  logic [2*CW+1:0]   s_x_off_i,
  output logic [2*CW+1:0]   addr_o
);
  localparam int AW = 2 * CW + 2;
  localparam int RW = CW + 3;

  logic [RW-1:0] col_q, rbytes_q, cur_col, cur_rbytes, col_nx;
  logic [AW-1:0] rb_q, xo_q, lb_q, cur_rb, cur_xo, cur_lb;

  always_comb begin
    cur_col    = fresh_i ? '0             : col_q;
    cur_rbytes = fresh_i ? s_row_bytes_i  : rbytes_q;
    cur_rb     = fresh_i ? s_row_base_i   : rb_q;
    cur_xo     = fresh_i ? s_x_off_i      : xo_q;
    cur_lb     = fresh_i ? s_line_bytes_i : lb_q;
    col_nx     = cur_col + RW'(2);
    addr_o     = cur_rb + cur_xo + AW'(cur_col);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0; rbytes_q <= '0; rb_q <= '0; xo_q <= '0; lb_q <= '0;
    end else if (load_i) begin
      col_q <= '0; rbytes_q <= s_row_bytes_i; rb_q <= s_row_base_i;
      xo_q <= s_x_off_i; lb_q <= s_line_bytes_i;
    end else if (step_i) begin
      rbytes_q <= cur_rbytes;
      xo_q     <= cur_xo;
      lb_q     <= cur_lb;
      // a row is never narrower than one word, so one wrap suffices
      if (col_nx >= cur_rbytes) begin
        col_q <= col_nx - cur_rbytes;
        rb_q  <= cur_rb + cur_lb;
      end else begin
        col_q <= col_nx;
        rb_q  <= cur_rb;
      end
    end
  end
endmodule

// File: rtl/pwx_dirty_axis.sv
`timescale 1ns/1ps
module pwx_dirty_axis #(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          consume_i,
  input  logic          grow_i,
  input  logic [CW-1:0] start_i,
  input  logic [CW:0]   size_i,
  input  logic [CW-1:0] extent_i,
  output logic [CW:0]   lo_o,
  output logic [CW:0]   hi_o
);
  localparam int DW = CW + 1;

  logic [DW-1:0] base_lo, base_hi, w_lo, w_hi;

  always_comb begin
    base_lo = consume_i ? DW'(extent_i) : lo_o;
    base_hi = consume_i ? '0 : hi_o;
    w_lo    = DW'(start_i);
    w_hi    = DW'(start_i) + size_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_o <= DW'(1) << CW;
      hi_o <= '0;
    end else if (grow_i) begin
      lo_o <= (w_lo < base_lo) ? w_lo : base_lo;
      hi_o <= (w_hi > base_hi) ? w_hi : base_hi;
    end else if (consume_i) begin
      lo_o <= base_lo;
      hi_o <= base_hi;
    end
  end
endmodule

// File: rtl/pix_window_xfer.sv
`timescale 1ns/1ps
module pix_window_xfer #(
  parameter int CW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CW-1:0]     win_xs_i,
  input  logic [CW-1:0]     win_ys_i,
  input  logic [CW-1:0]     win_xe_i,
  input  logic [CW-1:0]     win_ye_i,
  input  logic [3:0]        fmt_i,
  input  logic [2:0]        src_sel_i,
  input  logic              src_wr_i,
  input  logic              data_wr_i,
  input  logic [15:0]       data_i,
  input  logic [CW-1:0]     panel_w_i,
  input  logic [CW-1:0]     panel_h_i,
  input  logic              consume_i,
  output logic              fb_we_o,
  output logic [2*CW+1:0]   fb_addr_o,
  output logic [15:0]       fb_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [CW:0]       dirty_x0_o,
  output logic [CW:0]       dirty_y0_o,
  output logic [CW:0]       dirty_x1_o,
  output logic [CW:0]       dirty_y1_o
);
  localparam int DW = CW + 1;
  localparam int AW = 2 * CW + 2;
  localparam int NW = 2 * CW + 2;
  localparam int RW = CW + 3;

  logic          s_ok;
  logic [DW-1:0] s_dx, s_dy;
  logic [NW-1:0] s_len;
  logic [RW-1:0] s_row_bytes;
  logic [AW-1:0] s_line_bytes, s_row_base, s_x_off;

  pwx_setup #(.CW(CW)) i_setup (
    .xs_i(win_xs_i), .ys_i(win_ys_i), .xe_i(win_xe_i), .ye_i(win_ye_i),
    .fmt_i(fmt_i), .src_i(src_sel_i), .panel_w_i(panel_w_i),
    .ok_o(s_ok), .dx_o(s_dx), .dy_o(s_dy), .len_o(s_len),
    .row_bytes_o(s_row_bytes), .line_bytes_o(s_line_bytes),
    .row_base_o(s_row_base), .x_off_o(s_x_off)
  );

  logic [NW-1:0] rem_q, cur_rem;
  logic          fresh, accept, load, last, done_q, err_q;
  logic [CW-1:0] gx_q, gy_q, cur_gx, cur_gy;
  logic [DW-1:0] gdx_q, gdy_q, cur_gdx, cur_gdy;

  always_comb begin
    fresh   = (rem_q == '0);
    load    = src_wr_i & s_ok;
    accept  = data_wr_i & ~src_wr_i & (~fresh | s_ok);
    cur_rem = fresh ? s_len : rem_q;
    last    = accept & (cur_rem == NW'(1));
    cur_gx  = fresh ? win_xs_i : gx_q;
    cur_gy  = fresh ? win_ys_i : gy_q;
    cur_gdx = fresh ? s_dx : gdx_q;
    cur_gdy = fresh ? s_dy : gdy_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0; done_q <= 1'b0; err_q <= 1'b0;
      gx_q <= '0; gy_q <= '0; gdx_q <= '0; gdy_q <= '0;
    end else begin
      done_q <= last;
      if (data_wr_i & ~src_wr_i & fresh & ~s_ok) err_q <= 1'b1;
      if (load) rem_q <= s_len;
      else if (accept) rem_q <= cur_rem - NW'(1);
      if (load | (accept & fresh)) begin
        gx_q <= win_xs_i; gy_q <= win_ys_i; gdx_q <= s_dx; gdy_q <= s_dy;
      end
    end
  end

  pwx_addr #(.CW(CW)) i_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .step_i(accept), .fresh_i(fresh),
    .s_row_bytes_i(s_row_bytes), .s_line_bytes_i(s_line_bytes),
    .s_row_base_i(s_row_base), .s_x_off_i(s_x_off), .addr_o(fb_addr_o)
  );

  pwx_dirty_axis #(.CW(CW)) i_dirty_x (
    .clk_i(clk_i), .rst_ni(rst_ni), .consume_i(consume_i), .grow_i(last),
    .start_i(cur_gx), .size_i(cur_gdx), .extent_i(panel_w_i),
    .lo_o(dirty_x0_o), .hi_o(dirty_x1_o)
  );

  pwx_dirty_axis #(.CW(CW)) i_dirty_y (
    .clk_i(clk_i), .rst_ni(rst_ni), .consume_i(consume_i), .grow_i(last),
    .start_i(cur_gy), .size_i(cur_gdy), .extent_i(panel_h_i),
    .lo_o(dirty_y0_o), .hi_o(dirty_y1_o)
  );

  assign fb_we_o   = accept;
  assign fb_data_o = data_i;
  assign busy_o    = ~fresh;
  assign done_o    = done_q;
  assign err_o     = err_q;
endmodule

// File: rtl/pwx_checker.sv
`timescale 1ns/1ps
module pwx_checker #(
  parameter int CW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          src_wr_i,
  input logic          data_wr_i,
  input logic          consume_i,
  input logic          fb_we_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic [CW:0]   dirty_x0_o,
  input logic [CW:0]   dirty_y0_o,
  input logic [CW:0]   dirty_x1_o,
  input logic [CW:0]   dirty_y1_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else armed <= 1'b1;
  end

  AST_WE_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_we_o |-> (data_wr_i && !src_wr_i)); // R4

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && done_o) |-> $past(fb_we_o)); // R7

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R7

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R10

  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $rose(err_o)) |-> $past(data_wr_i && !src_wr_i && !busy_o)); // R2

  AST_DIRTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !done_o && !$past(consume_i)) |->
      ($stable(dirty_x0_o) && $stable(dirty_x1_o) &&
       $stable(dirty_y0_o) && $stable(dirty_y1_o))); // R8
endmodule

bind pix_window_xfer pwx_checker #(.CW(CW)) i_pwx_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_wr_i(src_wr_i), .data_wr_i(data_wr_i),
  .consume_i(consume_i), .fb_we_o(fb_we_o), .busy_o(busy_o), .done_o(done_o),
  .err_o(err_o), .dirty_x0_o(dirty_x0_o), .dirty_y0_o(dirty_y0_o),
  .dirty_x1_o(dirty_x1_o), .dirty_y1_o(dirty_y1_o)
);

// File: tb/test_pix_window_xfer.sv
`timescale 1ns/1ps
module test_pix_window_xfer;
  localparam int CW = 6;
  localparam int AW = 2 * CW + 2;
  localparam int PWID = 40;
  localparam int PHGT = 30;

  logic clk_i = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic          rst_ni;
  logic [CW-1:0] win_xs_i, win_ys_i, win_xe_i, win_ye_i;
  logic [3:0]    fmt_i;
  logic [2:0]    src_sel_i;
  logic          src_wr_i, data_wr_i, consume_i;
  logic [15:0]   data_i;
  logic [CW-1:0] panel_w_i, panel_h_i;
  logic          fb_we_o, busy_o, done_o, err_o;
  logic [AW-1:0] fb_addr_o;
  logic [15:0]   fb_data_o;
  logic [CW:0]   dirty_x0_o, dirty_y0_o, dirty_x1_o, dirty_y1_o;

  pix_window_xfer #(.CW(CW)) i_pix_window_xfer (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .win_xs_i(win_xs_i), .win_ys_i(win_ys_i), .win_xe_i(win_xe_i), .win_ye_i(win_ye_i),
    .fmt_i(fmt_i), .src_sel_i(src_sel_i), .src_wr_i(src_wr_i),
    .data_wr_i(data_wr_i), .data_i(data_i),
    .panel_w_i(panel_w_i), .panel_h_i(panel_h_i), .consume_i(consume_i),
    .fb_we_o(fb_we_o), .fb_addr_o(fb_addr_o), .fb_data_o(fb_data_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .dirty_x0_o(dirty_x0_o), .dirty_y0_o(dirty_y0_o),
    .dirty_x1_o(dirty_x1_o), .dirty_y1_o(dirty_y1_o)
  );

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;
  int mx0, my0, mx1, my1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int fbytes(input int f);
    case (f)
      1:       return 2;
      2, 3:    return 3;
      6, 7:    return 4;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_addr(input int xs, ys, dx, bpp, k);
    int rb = bpp * dx;
    int r  = (2 * k) / rb;
    int c  = (2 * k) % rb;
    return ((ys + r) * PWID + xs) * bpp + c;
  endfunction

  function automatic int imin(input int a, b); return (a < b) ? a : b; endfunction
  function automatic int imax(input int a, b); return (a > b) ? a : b; endfunction

  task automatic check_dirty(input string req);
    int act = int'(dirty_x0_o) * 1000000 + int'(dirty_y0_o) * 10000 + int'(dirty_x1_o) * 100 + int'(dirty_y1_o);
    int exp = mx0 * 1000000 + my0 * 10000 + mx1 * 100 + my1;
    check(act == exp, req, act, exp);
  endtask

  // writes words k0..len-1 of a window with the given geometry
  task automatic stream(input int xs, ys, dx, dy, bpp, k0, input bit cons, input string req);
    int len = (bpp * dx * dy) / 2;
    for (int k = k0; k < len; k++) begin
      int ea;
      @(negedge clk_i);
      data_wr_i = 1'b1;
      data_i = 16'($urandom);
      if (k == len - 1 && cons) consume_i = 1'b1;
      #1;
      ea = exp_addr(xs, ys, dx, bpp, k);
      check(fb_we_o === 1'b1 && int'(fb_addr_o) == ea && fb_data_o == data_i,
            {req, " R6 word write"}, int'(fb_addr_o), ea);
      if (k == 1 && k0 == 0) check(busy_o === 1'b1, "R5 busy after lazy setup", int'(busy_o), 1);
    end
    @(negedge clk_i);
    data_wr_i = 1'b0;
    consume_i = 1'b0;
    #1;
    check(done_o === 1'b1 && busy_o === 1'b0, {req, " R3 R7 done after last word"}, int'(done_o), 1);
    if (cons) begin mx0 = PWID; mx1 = 0; my0 = PHGT; my1 = 0; end
    mx0 = imin(mx0, xs); my0 = imin(my0, ys);
    mx1 = imax(mx1, xs + dx); my1 = imax(my1, ys + dy);
    check_dirty({req, " R8 dirty union"});
    @(negedge clk_i);
    #1;
    check(done_o === 1'b0, "R7 done single pulse", int'(done_o), 0);
  endtask

  task automatic set_cfg(input int xs, ys, xe, ye, fmt, src);
    win_xs_i = CW'(xs); win_ys_i = CW'(ys); win_xe_i = CW'(xe); win_ye_i = CW'(ye);
    fmt_i = 4'(fmt); src_sel_i = 3'(src);
  endtask

  task automatic run_window(input int xs, ys, xe, ye, fmt, input bit cons, input string req);
    @(negedge clk_i);
    set_cfg(xs, ys, xe, ye, fmt, int'($urandom_range(0, 3)));
    stream(xs, ys, xe - xs + 1, ye - ys + 1, fbytes(fmt), 0, cons, req);
  endtask

  task automatic try_bad(input int xs, ys, xe, ye, fmt, src, input string req);
    @(negedge clk_i);
    set_cfg(xs, ys, xe, ye, fmt, src);
    data_wr_i = 1'b1;
    data_i = 16'hbeef;
    #1;
    check(fb_we_o === 1'b0, {req, " R2 dropped word"}, int'(fb_we_o), 0);
    @(negedge clk_i);
    data_wr_i = 1'b0;
    #1;
    check(busy_o === 1'b0 && err_o === 1'b1, {req, " R2 R10 idle with error"}, int'(err_o), 1);
    check_dirty({req, " R2 dirty untouched"});
  endtask

  task automatic do_consume();
    @(negedge clk_i);
    consume_i = 1'b1;
    @(negedge clk_i);
    consume_i = 1'b0;
    #1;
    mx0 = PWID; mx1 = 0; my0 = PHGT; my1 = 0;
    check_dirty("R9 consume empties rectangle");
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    rst_ni = 1'b0;
    set_cfg(0, 0, 0, 0, 3, 0);
    src_wr_i = 1'b0; data_wr_i = 1'b0; consume_i = 1'b0; data_i = '0;
    panel_w_i = CW'(PWID); panel_h_i = CW'(PHGT);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    mx0 = 1 << CW; my0 = 1 << CW; mx1 = 0; my1 = 0;
    check(busy_o === 1'b0 && done_o === 1'b0 && err_o === 1'b0 && fb_we_o === 1'b0,
          "R11 reset outputs", int'(busy_o), 0);
    check_dirty("R11 reset dirty empty");

    // directed: one window per supported format
    run_window(2, 3, 5, 4, 1, 0, "R1 R3 fmt1");
    run_window(7, 1, 7, 1, 2, 0, "R1 R3 fmt2 single pixel");
    run_window(0, 0, 2, 2, 3, 0, "R1 R3 fmt3 odd count");
    run_window(10, 5, 12, 6, 6, 0, "R1 fmt6");
    run_window(1, 9, 1, 11, 7, 0, "R1 fmt7 column");
    check(err_o === 1'b0, "R10 no error on valid windows", int'(err_o), 0);

    // invalid setups
    try_bad(0, 0, 3, 3, 4, 0, "R1 R2 unsupported fmt4");
    try_bad(0, 0, 3, 3, 0, 0, "R1 R2 unsupported fmt0");
    try_bad(0, 0, 3, 3, 1, 5, "R2 source above 3");
    try_bad(5, 0, 4, 3, 1, 0, "R2 end X below start");
    try_bad(0, 6, 3, 5, 1, 0, "R2 end Y below start");

    // restart by source write, data in same cycle dropped
    @(negedge clk_i);
    set_cfg(0, 0, 3, 1, 1, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i); data_wr_i = 1'b1; data_i = 16'(k);
    end
    @(negedge clk_i);
    set_cfg(10, 5, 11, 5, 7, 2);
    src_wr_i = 1'b1;
    #1;
    check(fb_we_o === 1'b0, "R4 data beside source write dropped", int'(fb_we_o), 0);
    @(negedge clk_i);
    src_wr_i = 1'b0; data_wr_i = 1'b0;
    #1;
    check(busy_o === 1'b1, "R4 source write opens transfer", int'(busy_o), 1);
    set_cfg(0, 0, 0, 0, 0, 7);
    stream(10, 5, 2, 1, 4, 0, 0, "R4 restarted window");

    // failing source write mid-transfer leaves transfer intact
    @(negedge clk_i);
    set_cfg(20, 2, 23, 3, 1, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i); data_wr_i = 1'b1; data_i = 16'(k);
    end
    @(negedge clk_i);
    data_wr_i = 1'b0;
    set_cfg(9, 9, 1, 1, 4, 6);
    src_wr_i = 1'b1;
    @(negedge clk_i);
    src_wr_i = 1'b0;
    #1;
    check(busy_o === 1'b1, "R4 invalid source write ignored", int'(busy_o), 1);
    stream(20, 2, 4, 2, 2, 3, 0, "R4 resumed window");

    do_consume();
    run_window(4, 4, 6, 5, 1, 1, "R9 consume with completion");
    run_window(60, 62, 63, 63, 3, 0, "R8 max corner");
    do_consume();

    // random windows
    for (int i = 0; i < 60; i++) begin
      int dx = $urandom_range(1, 5);
      int dy = $urandom_range(1, 5);
      int xs = $urandom_range(0, 64 - dx);
      int ys = $urandom_range(0, 64 - dy);
      int fsel = $urandom_range(0, 4);
      int fmt = (fsel == 0) ? 1 : (fsel == 1) ? 2 : (fsel == 2) ? 3 : (fsel == 3) ? 6 : 7;
      run_window(xs, ys, xs + dx - 1, ys + dy - 1, fmt, (i % 9 == 4), "R3 random");
      if (i % 7 == 6) do_consume();
    end
    check(err_o === 1'b1, "R10 error still set", int'(err_o), 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule